// File: doc/BRIEF.md
# Programmable-Modulus Fractional Interpolator

This block produces, once per reference clock cycle, the integer division value for the counter of a fractional-N divider. Over time the mean of those values equals INT + FRAC/MOD. INT is a 9-bit integer part. FRAC and MOD are 12-bit words, and MOD may be any value, not only a power of two. A smaller or larger modulus moves the balance between noise and spurious tones.

Three first-order accumulators are chained, and each of them wraps at MOD. The carries of the three stages are recombined through difference terms, so the quantization error is shaped to the third order. The result is a small signed correction that is added to INT.

A single load strobe takes the three configuration words together and restarts the modulator from a clean state.

Top module: `fracNInterp`

## Requirements
- R1: While reset (rstN low) is asserted, and afterwards until the first load, divOut is 0. The held configuration is then INT=0, FRAC=0, MOD=1.
- R2: At a rising clock edge where loadStb is high, intIn, fracIn and modIn are captured together. At the same edge every accumulator and every carry delay register is cleared, and divOut becomes the new INT with no correction. A load takes precedence over the modulator step of that edge.
- R3: When loadStb is low, changes on intIn, fracIn and modIn have no effect on divOut.
- R4: Each stage k forms s = acc_k + a_k. Stage 1 uses a_1 = FRAC, and stage k>1 uses the residue of stage k-1 from the same cycle. The carry c_k is 1 when s >= MOD. The new residue is s-MOD when the carry is set and s otherwise. With FRAC < MOD, every residue stays below MOD.
- R5: At each rising edge without a load, divOut becomes INT + y, where y = c1 + c2 - c2' + c3 - 2*c3' + c3''. One prime marks the value one step earlier and two primes mark two steps earlier. Both delayed values are zero right after a load.
- R6: For INT >= 3, divOut - INT always lies between -3 and +4.
- R7: With FRAC = 0, divOut equals INT on every cycle.
- R8: Let N be the number of steps since a load. The sum of (divOut - INT) over the first N outputs, minus floor(N*FRAC/MOD), is always in the range -1 to +2. The long-run mean is therefore INT + FRAC/MOD for any modulus.
- R9: Loads on consecutive edges each restart the sequence. Only the last one decides the configuration used by the following steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (phase detector) clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Capture configuration and restart modulator |
| intIn | input | 9 | Integer part of the division ratio |
| fracIn | input | 12 | Fractional numerator, must be below modIn |
| modIn | input | 12 | Fractional modulus, at least 1 |
| divOut | output | 10 | Instantaneous division value for the divider counter |

## Verification
A load strobe and a modulator step that would produce carries can fall on the same edge. To provoke this, the bench runs a configuration whose carries fire almost every cycle for a few steps and then raises loadStb in the middle of the sequence. The step must be discarded: divOut must show the new INT exactly, and the outputs that follow must match a sequence restarted from cleared accumulators and delays, not one continued from the old residues. Back-to-back loads are judged the same way, each one restarting the expected sequence.

// File: rtl/fracNInterpPkg.sv
package fracNInterpPkg;

  // Number of cascaded accumulators; the recombination network is third order.
  localparam int STAGES = 3;
  // Signed correction width: holds the range -3 .. +4.
  localparam int CORR_W = 4;

  // Strobes handed from the control block to the datapath.
  typedef struct packed {
    logic clearAll;  // clear accumulators, carry history and force the plain integer
    logic step;      // advance the modulator by one reference cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/fracNInterpCtrl.sv
module fracNInterpCtrl
  import fracNInterpPkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [INT_W-1:0]  intIn,
  input  logic [FRAC_W-1:0] fracIn,
  input  logic [FRAC_W-1:0] modIn,
  output ctrlStrobes_t      strobes,
  output logic [INT_W-1:0]  intNext,
  output logic [INT_W-1:0]  cfgInt,
  output logic [FRAC_W-1:0] cfgFrac,
  output logic [FRAC_W-1:0] cfgMod
);

  localparam logic [FRAC_W-1:0] MOD_RESET = FRAC_W'(1);

  // Configuration words are taken as one set; a load suppresses stepping.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgInt  <= '0;
      cfgFrac <= '0;
      cfgMod  <= MOD_RESET;
    end else if (loadStb) begin
      cfgInt  <= intIn;
      cfgFrac <= fracIn;
      cfgMod  <= modIn;
    end
  end

  always_comb begin
    strobes.clearAll = loadStb;
    strobes.step     = !loadStb;
  end

  // Integer value the output must show right after this edge when loading.
  assign intNext = loadStb ? intIn : cfgInt;

endmodule

// File: rtl/fracNInterpPath.sv
module fracNInterpPath
  import fracNInterpPkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [INT_W-1:0]              intNext,
  input  logic [INT_W-1:0]              cfgInt,
  input  logic [FRAC_W-1:0]             cfgFrac,
  input  logic [FRAC_W-1:0]             cfgMod,
  output logic [STAGES-1:0][FRAC_W-1:0] accState,
  output logic [INT_W:0]                divOut
);

  localparam int OUT_W = INT_W + 1;
  localparam int SUM_W = FRAC_W + 1;

  logic [STAGES-1:0][FRAC_W-1:0] accQ;
  logic [STAGES-1:0][FRAC_W-1:0] accD;
  logic [STAGES-1:0]             carry;

  // Cascade: each stage adds the residue of the previous stage of this cycle.
  for (genvar k = 0; k < STAGES; k++) begin : gStage
    logic [FRAC_W-1:0] addend;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  wrapped;

    if (k == 0) begin : gFirst
      assign addend = cfgFrac;
    end else begin : gNext
      assign addend = accD[k-1];
    end

    assign sum      = {1'b0, accQ[k]} + {1'b0, addend};
    assign carry[k] = (sum >= {1'b0, cfgMod});
    assign wrapped  = sum - {1'b0, cfgMod};
    assign accD[k]  = carry[k] ? wrapped[FRAC_W-1:0] : sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      accQ <= '0;
    end else if (strobes.step) begin
      accQ <= accD;
    end
  end

  // Carry history for the difference terms of stages two and three.
  logic c2Dly;
  logic c3Dly;
  logic c3Dly2;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      c2Dly  <= 1'b0;
      c3Dly  <= 1'b0;
      c3Dly2 <= 1'b0;
    end else if (strobes.step) begin
      c2Dly  <= carry[1];
      c3Dly  <= carry[2];
      c3Dly2 <= c3Dly;
    end
  end

  // Noise-cancelling recombination in two's complement, range -3 .. +4.
  logic [CORR_W-1:0] corrU;
  logic [OUT_W-1:0]  corrExt;
  logic [OUT_W-1:0]  divNext;

  assign corrU = CORR_W'(carry[0])
               + CORR_W'(carry[1]) - CORR_W'(c2Dly)
               + CORR_W'(carry[2]) - CORR_W'({c3Dly, 1'b0}) + CORR_W'(c3Dly2);

  assign corrExt = {{(OUT_W-CORR_W){corrU[CORR_W-1]}}, corrU};
  assign divNext = {1'b0, cfgInt} + corrExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divOut <= '0;
    end else if (strobes.clearAll) begin
      divOut <= {1'b0, intNext};
    end else if (strobes.step) begin
      divOut <= divNext;
    end
  end

  assign accState = accQ;

endmodule

// File: rtl/fracNInterp.sv
module fracNInterp
  import fracNInterpPkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [INT_W-1:0]  intIn,
  input  logic [FRAC_W-1:0] fracIn,
  input  logic [FRAC_W-1:0] modIn,
  output logic [INT_W:0]    divOut
);

  ctrlStrobes_t                  strobes;
  logic [INT_W-1:0]              intNext;
  logic [INT_W-1:0]              cfgInt;
  logic [FRAC_W-1:0]             cfgFrac;
  logic [FRAC_W-1:0]             cfgMod;
  logic [STAGES-1:0][FRAC_W-1:0] accState;

  fracNInterpCtrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .intIn   (intIn),
    .fracIn  (fracIn),
    .modIn   (modIn),
    .strobes (strobes),
    .intNext (intNext),
    .cfgInt  (cfgInt),
    .cfgFrac (cfgFrac),
    .cfgMod  (cfgMod)
  );

  fracNInterpPath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) pathI (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .intNext  (intNext),
    .cfgInt   (cfgInt),
    .cfgFrac  (cfgFrac),
    .cfgMod   (cfgMod),
    .accState (accState),
    .divOut   (divOut)
  );

endmodule

// File: rtl/fracNInterpChk.sv
module fracNInterpChk
  import fracNInterpPkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          loadStb,
  input logic [INT_W-1:0]              intIn,
  input logic [INT_W:0]                divOut,
  input logic [INT_W-1:0]              cfgInt,
  input logic [FRAC_W-1:0]             cfgFrac,
  input logic [FRAC_W-1:0]             cfgMod,
  input logic [STAGES-1:0][FRAC_W-1:0] accState
);

  logic signed [INT_W+2:0] deltaOut;
  assign deltaOut = $signed({2'b0, divOut}) - $signed({3'b0, cfgInt});

  AST_LOAD_SHOWS_INT: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> divOut == {1'b0, $past(intIn)}); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> ($stable(cfgInt) && $stable(cfgFrac) && $stable(cfgMod))); // R3

  AST_RESIDUE_BELOW_MOD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFrac < cfgMod) |->
      (accState[0] < cfgMod && accState[1] < cfgMod && accState[2] < cfgMod)); // R4

  AST_CORR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgInt >= INT_W'(3)) |-> (deltaOut >= -3 && deltaOut <= 4)); // R6

  AST_ZERO_FRAC_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFrac == '0) |-> divOut == {1'b0, cfgInt}); // R7

endmodule

bind fracNInterp fracNInterpChk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .loadStb  (loadStb),
  .intIn    (intIn),
  .divOut   (divOut),
  .cfgInt   (cfgInt),
  .cfgFrac  (cfgFrac),
  .cfgMod   (cfgMod),
  .accState (accState)
);

// File: tb/fracNInterp_tb_top.sv
module fracNInterp_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // Columns: INT, FRAC, MOD, number of steps
  localparam int VEC [NVEC][4] = '{
    '{100,    0, 4095, 30},
    '{100,    1,    7, 60},
    '{200,    3,    5, 60},
    '{ 37, 2048, 4095, 50},
    '{508, 4094, 4095, 50},
    '{  3,    1,    2, 40},
    '{ 64,    5,    8, 40},
    '{300, 1000, 1001, 50}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadStb;
  logic [8:0]  intIn;
  logic [11:0] fracIn;
  logic [11:0] modIn;
  logic [9:0]  divOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // Reference state built from the requirement equations.
  int mA1, mA2, mA3, mC2d, mC3d, mC3dd, mInt, mFrac, mMod;
  int stepsSinceLoad, cumDelta;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracNInterp dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .intIn   (intIn),
    .fracIn  (fracIn),
    .modIn   (modIn),
    .divOut  (divOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stage(inout int acc, input int addend, output int carry, output int resid);
    int s;
    s = acc + addend;
    carry = (s >= mMod) ? 1 : 0;
    resid = carry ? s - mMod : s;
    acc = resid;
  endtask

  task automatic modelStep(output int expOut);
    int c1, c2, c3, r1, r2, r3, y;
    stage(mA1, mFrac, c1, r1);
    stage(mA2, r1, c2, r2);
    stage(mA3, r2, c3, r3);
    y = c1 + c2 - mC2d + c3 - 2*mC3d + mC3dd;
    mC3dd = mC3d;
    mC3d  = c3;
    mC2d  = c2;
    expOut = mInt + y;
  endtask

  task automatic modelLoad(input int i, input int f, input int m);
    mInt = i; mFrac = f; mMod = m;
    mA1 = 0; mA2 = 0; mA3 = 0; mC2d = 0; mC3d = 0; mC3dd = 0;
    stepsSinceLoad = 0; cumDelta = 0;
  endtask

  // Called at a negedge: pulse load for one edge, then check the output.
  task automatic doLoad(input int i, input int f, input int m);
    loadStb = 1'b1;
    intIn = 9'(i); fracIn = 12'(f); modIn = 12'(m);
    @(posedge clk);
    @(negedge clk);
    loadStb = 1'b0;
    modelLoad(i, f, m);
    check(int'(divOut) == i, "R2 load output", int'(divOut), i);
  endtask

  // Called at a negedge: one step and full comparison.
  task automatic doStep(input bit fullChecks);
    int expOut, act, d, bound;
    modelStep(expOut);
    @(posedge clk);
    @(negedge clk);
    act = int'(divOut);
    check(act == expOut, "R4 R5 sequence", act, expOut);
    if (fullChecks) begin
      stepsSinceLoad++;
      d = act - mInt;
      cumDelta += d;
      check(d >= -3 && d <= 4, "R6 range", d, 0);
      bound = cumDelta - (stepsSinceLoad * mFrac) / mMod;
      check(bound >= -1 && bound <= 2, "R8 mean", bound, 0);
      if (mFrac == 0) check(act == mInt, "R7 flat", act, mInt);
    end
  endtask

  initial begin
    rstN = 1'b0; loadStb = 1'b0; intIn = '0; fracIn = '0; modIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(divOut == 10'd0, "R1 in reset", int'(divOut), 0);
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(divOut == 10'd0, "R1 before load", int'(divOut), 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      doLoad(VEC[v][0], VEC[v][1], VEC[v][2]);
      for (int n = 0; n < VEC[v][3]; n++) doStep(1'b1);
    end

    // R3: inputs move while loadStb is low
    doLoad(150, 2, 9);
    for (int n = 0; n < 12; n++) begin
      intIn = 9'(7 + n); fracIn = 12'(8 + n); modIn = 12'(3 + n);
      doStep(1'b1);
    end
    check(int'(divOut) >= 147, "R3 config kept", int'(divOut), 150);

    // R2: load lands on an edge where the step would carry
    doLoad(50, 4, 5);
    for (int n = 0; n < 4; n++) doStep(1'b1);
    doLoad(60, 4, 5);
    for (int n = 0; n < 15; n++) doStep(1'b1);

    // R9: two loads on consecutive edges
    loadStb = 1'b1; intIn = 9'd90; fracIn = 12'd1; modIn = 12'd3;
    @(posedge clk);
    @(negedge clk);
    check(int'(divOut) == 90, "R9 first load", int'(divOut), 90);
    intIn = 9'd120; fracIn = 12'd5; modIn = 12'd11;
    @(posedge clk);
    @(negedge clk);
    loadStb = 1'b0;
    check(int'(divOut) == 120, "R9 second load", int'(divOut), 120);
    modelLoad(120, 5, 11);
    for (int n = 0; n < 30; n++) doStep(1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule